// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break and Idle Preamble

This block turns parallel words into an asynchronous serial bit stream. A word written into the holding register moves into the shift register at the next free bit slot and leaves the line as a frame: one low start bit, the data bits least significant first, and one high stop bit. In 8-bit mode a frame is 10 bit times long; in 9-bit mode it is 11. A single-cycle `bit_tick` pulse marks each bit boundary. The block does not count baud periods itself.

The block has two other kinds of line traffic. While `send_brk` is held high, it sends back-to-back break characters. A break character is all zeros, one frame length long, with no start or stop bit. After `send_brk` is released, at least one high bit follows the last break. A rising edge on `tx_en` queues a preamble, which is one frame length of high bits sent before anything else. Dropping `tx_en` does not cut off the frame in flight: that frame completes and the line then rests high. Two flags report progress. `hold_empty` shows whether the holding register can take a new word. `all_sent` shows that nothing is being shifted and nothing is waiting.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1 and `all_sent` is 1. Whenever the shift register holds nothing, `txd` is 1.
- R2: In 8-bit mode (`nine_bit`=0), a data frame is 0, then `wr_val[7:0]` least significant bit first, then 1. That is 10 bits, each lasting from one `bit_tick` to the next. The first bit appears the clock after the tick at which the shifter is free.
- R3: In 9-bit mode (`nine_bit`=1, sampled when a frame is loaded), a frame carries `wr_val[8:0]` and is 11 bits long.
- R4: A `wr_stb` pulse stores `wr_val` and clears `hold_empty` on the next clock. `hold_empty` rises on the clock after the tick that moves the word into the shift register. A write in that same cycle keeps `hold_empty` low.
- R5: `all_sent` is 1 only when all of the following hold:
  - the shift register holds nothing;
  - no preamble is pending;
  - no mark bit is owed after a break;
  - `hold_empty` is 1;
  - `send_brk` is 0.
- R6: Lowering `tx_en` lets the frame in progress finish. Afterwards the line stays at 1, and no new frame, break or preamble starts while `tx_en` is 0.
- R7: A 0-to-1 change of `tx_en` (including the first one after reset) queues a preamble. The preamble is 10 (8-bit mode) or 11 (9-bit mode) consecutive 1 bits, sent ahead of the next frame. The pending preamble is dropped if `tx_en` falls again before it starts.
- R8: While `send_brk` is 1 and `tx_en` is 1, each free slot loads a break character of 10 or 11 zero bits (per `nine_bit`), back to back.
- R9: When a break character ends and `send_brk` is 0, exactly one 1 bit is sent before any data frame.
- R10: When the shifter becomes free, the next item is chosen in this order: a pending preamble, then a break, then the owed mark bit, then held data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_en | input | 1 | Transmitter enable |
| send_brk | input | 1 | Hold high to send break characters |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_val | input | DW+1 | Word to send (top bit used in 9-bit mode) |
| txd | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding register can accept a word |
| all_sent | output | 1 | Nothing shifting and nothing pending |

## Verification
The hardest situation to reach is a moment when several sources compete for the same free slot. In that moment a preamble is pending, `send_brk` is high and a word is waiting, all at once. The stimulus gets there by holding `tx_en` low while it writes a word and raises `send_brk`. Because nothing can load while `tx_en` is low, all three wait. Raising `tx_en` then releases them together, and the bench expects preamble, break, mark bit and data frame in that order. A second hard case is a disable that falls mid-frame: the stimulus lowers `tx_en` a few ticks into a frame and writes another word while disabled, and the line must finish the old frame and then stay high.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [2:0] {
        SEL_IDLE,
        SEL_PRE,
        SEL_BRK,
        SEL_MARK,
        SEL_DATA
    } tx_sel_e;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int HW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [HW-1:0] wr_val,
    input  logic          take,
    output logic [HW-1:0] dreg,
    output logic          empty
);
    typedef struct packed {
        logic [HW-1:0] data;
        logic          empty;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (take) h_d.empty = 1'b1;
        if (wr) begin
            h_d.data  = wr_val;
            h_d.empty = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q.data  <= '0;
            h_q.empty <= 1'b1;
        end else begin
            h_q <= h_d;
        end
    end

    assign dreg  = h_q.data;
    assign empty = h_q.empty;

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !empty); // R4
    AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr) |=> empty); // R4
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
    parameter int SW = 10,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ld_first,
    input  logic [SW-1:0] ld_rest,
    input  logic [CW-1:0] ld_len,
    output logic          txd,
    output logic          slot,
    output logic          busy
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [SW-1:0] sr;
        logic          line;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick) begin
            if (s_q.cnt > CW'(1)) begin
                s_d.line = s_q.sr[0];
                s_d.sr   = {1'b1, s_q.sr[SW-1:1]};
                s_d.cnt  = s_q.cnt - CW'(1);
            end else begin
                s_d.line = ld_first;
                s_d.sr   = ld_rest;
                s_d.cnt  = ld_len;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt  <= '0;
            s_q.sr   <= '1;
            s_q.line <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign txd  = s_q.line;
    assign slot = (s_q.cnt <= CW'(1));
    assign busy = (s_q.cnt != '0);

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd); // R1
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(txd)); // R2
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk
    import uart_tx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_tick,
    input  logic        tx_en,
    input  logic        send_brk,
    input  logic        nine_bit,
    input  logic        wr_stb,
    input  logic [DW:0] wr_val,
    output logic        txd,
    output logic        hold_empty,
    output logic        all_sent
);
    localparam int HW   = DW + 1;
    localparam int SW   = DW + 2;
    localparam int FL_S = DW + 2;
    localparam int FL_L = DW + 3;
    localparam int CW   = $clog2(FL_L + 1);

    typedef struct packed {
        logic pre;
        logic lbrk;
        logic en;
    } sch_t;

    sch_t          c_d, c_q;
    tx_sel_e       sel;
    logic          slot, busy, take;
    logic [HW-1:0] dreg;
    logic          ld_first;
    logic [SW-1:0] ld_rest;
    logic [CW-1:0] ld_len, flen;

    assign take = bit_tick && slot;
    assign flen = nine_bit ? CW'(FL_L) : CW'(FL_S);

    always_comb begin
        if (!tx_en)               sel = SEL_IDLE;
        else if (c_q.pre)         sel = SEL_PRE;
        else if (send_brk)        sel = SEL_BRK;
        else if (c_q.lbrk)        sel = SEL_MARK;
        else if (!hold_empty)     sel = SEL_DATA;
        else                      sel = SEL_IDLE;
    end

    always_comb begin
        ld_first = 1'b1;
        ld_rest  = '1;
        ld_len   = '0;
        case (sel)
            SEL_PRE:  ld_len = flen;
            SEL_BRK: begin
                ld_first = 1'b0;
                ld_rest  = '0;
                ld_len   = flen;
            end
            SEL_MARK: ld_len = CW'(1);
            SEL_DATA: begin
                ld_first = 1'b0;
                ld_rest  = nine_bit ? {1'b1, dreg} : {2'b11, dreg[DW-1:0]};
                ld_len   = flen;
            end
            default: ;
        endcase
    end

    always_comb begin
        c_d     = c_q;
        c_d.en  = tx_en;
        c_d.pre = (tx_en && !c_q.en) ||
                  (c_q.pre && tx_en && !(take && sel == SEL_PRE));
        if (take) c_d.lbrk = (sel == SEL_BRK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    uart_tx_hold #(.HW(HW)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_stb),
        .wr_val (wr_val),
        .take   (take && sel == SEL_DATA),
        .dreg   (dreg),
        .empty  (hold_empty)
    );

    uart_tx_shift #(.SW(SW), .CW(CW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (bit_tick),
        .ld_first (ld_first),
        .ld_rest  (ld_rest),
        .ld_len   (ld_len),
        .txd      (txd),
        .slot     (slot),
        .busy     (busy)
    );

    assign all_sent = !busy && !c_q.pre && !c_q.lbrk && hold_empty && !send_brk;

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        all_sent |-> (txd && hold_empty)); // R5
    AST_BRK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (take && sel == SEL_BRK) |=> !txd); // R8
    AST_PRE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (take && sel == SEL_PRE) |=> (txd && !all_sent)); // R7
    AST_MARK_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        (take && c_q.lbrk && tx_en && !send_brk && !c_q.pre) |=> txd); // R9
    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !tx_en) |=> txd); // R6
endmodule

// File: tb/sim_uart_tx_brk.sv
`timescale 1ns/100ps
module sim_uart_tx_brk;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       tx_en = 1'b0;
    logic       send_brk = 1'b0;
    logic       nine_bit = 1'b0;
    logic       wr_stb = 1'b0;
    logic [8:0] wr_val = '0;
    logic       txd, hold_empty, all_sent;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int tdiv = 0;
    string phase = "R1 reset";

    bit   mq[$];
    bit   m_pre = 0, m_lb = 0, m_enq = 0, m_empty = 1;
    logic [8:0] m_dreg = '0;

    always #2 clk = ~clk;

    uart_tx_brk #(.DW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
        .send_brk(send_brk), .nine_bit(nine_bit), .wr_stb(wr_stb),
        .wr_val(wr_val), .txd(txd), .hold_empty(hold_empty), .all_sent(all_sent)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // behavioural reference: a queue of line bits still to be shown
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            mq.delete(); m_pre = 0; m_lb = 0; m_enq = 0; m_empty = 1; m_dreg = '0;
        end else begin
            int  choice;
            int  flen;
            bit  take;
            bit  new_lb;
            choice = 0;
            take = bit_tick && (mq.size() <= 1);
            flen = nine_bit ? 11 : 10;
            if (bit_tick && mq.size() > 1) begin
                void'(mq.pop_front());
            end else if (take) begin
                mq.delete();
                if (!tx_en) choice = 0;
                else if (m_pre) begin choice = 1; repeat (flen) mq.push_back(1'b1); end
                else if (send_brk) begin choice = 2; repeat (flen) mq.push_back(1'b0); end
                else if (m_lb) begin choice = 3; mq.push_back(1'b1); end
                else if (!m_empty) begin
                    choice = 4;
                    mq.push_back(1'b0);
                    for (int i = 0; i < (nine_bit ? 9 : 8); i++) mq.push_back(m_dreg[i]);
                    mq.push_back(1'b1);
                end
            end
            new_lb = take ? (choice == 2) : m_lb;
            m_pre  = (tx_en && !m_enq) || (m_pre && tx_en && !(take && choice == 1));
            if (take && choice == 4) m_empty = 1;
            if (wr_stb) begin m_dreg = wr_val; m_empty = 0; end
            m_enq = tx_en;
            m_lb  = new_lb;
        end
        #1;
        if (rst_n) begin
            bit exp_txd, exp_done;
            exp_txd  = (mq.size() == 0) ? 1'b1 : mq[0];
            exp_done = (mq.size() == 0) && !m_pre && !m_lb && m_empty && !send_brk;
            check(txd === exp_txd, phase, int'(txd), int'(exp_txd));
            check(hold_empty === m_empty, "R4 hold_empty", int'(hold_empty), int'(m_empty));
            check(all_sent === exp_done, "R5 all_sent", int'(all_sent), int'(exp_done));
        end
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            tdiv = (tdiv + 1) % 3;
            bit_tick = (tdiv == 0);
        end
    end

    task automatic put(input logic [8:0] v);
        @(negedge clk);
        wr_val = v; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic wait_empty();
        for (int k = 0; k < 400 && !hold_empty; k++) @(negedge clk);
    endtask

    task automatic wait_done();
        for (int k = 0; k < 1000 && !all_sent; k++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            while (!bit_tick) @(negedge clk);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd === 1'b1, "R1 idle line", int'(txd), 1);
        check(hold_empty === 1'b1, "R1 empty after reset", int'(hold_empty), 1);
        check(all_sent === 1'b1, "R1 done after reset", int'(all_sent), 1);

        phase = "R7 preamble then R2 8-bit frame";
        tx_en = 1'b1;
        put(9'h0A5);
        wait_empty();
        phase = "R4 back-to-back R2 frame";
        put(9'h03C);
        wait_done();
        check(all_sent === 1'b1, "R5 done after frames", int'(all_sent), 1);

        phase = "R3 9-bit frame";
        nine_bit = 1'b1;
        put(9'h1C3);
        wait_empty();
        put(9'h0FF);
        wait_done();
        nine_bit = 1'b0;

        phase = "R6 disable mid-frame";
        put(9'h055);
        wait_ticks(4);
        @(negedge clk);
        tx_en = 1'b0;
        wait_ticks(14);
        put(9'h0E1);
        wait_ticks(12);
        check(txd === 1'b1, "R6 line idle while off", int'(txd), 1);
        check(hold_empty === 1'b0, "R6 word held while off", int'(hold_empty), 0);
        phase = "R7 preamble on re-enable";
        tx_en = 1'b1;
        wait_done();

        phase = "R7 toggle drops then requeues";
        tx_en = 1'b0;
        @(negedge clk);
        tx_en = 1'b1;
        @(negedge clk);
        check(all_sent === 1'b0, "R7 preamble pending", int'(all_sent), 0);
        wait_done();

        phase = "R8 held break";
        send_brk = 1'b1;
        wait_ticks(27);
        phase = "R9 mark after break";
        send_brk = 1'b0;
        put(9'h081);
        wait_done();

        phase = "R8 9-bit break";
        nine_bit = 1'b1;
        send_brk = 1'b1;
        wait_ticks(5);
        send_brk = 1'b0;
        wait_done();
        nine_bit = 1'b0;

        phase = "R10 priority preamble break mark data";
        tx_en = 1'b0;
        wait_done();
        put(9'h066);
        send_brk = 1'b1;
        @(negedge clk);
        tx_en = 1'b1;
        wait_ticks(13);
        send_brk = 1'b0;
        wait_done();
        check(hold_empty === 1'b1, "R10 data sent last", int'(hold_empty), 1);
        check(txd === 1'b1, "R1 idle at end", int'(txd), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule